// File: doc/BRIEF.md
# Single-Bit Asynchronous Static RAM Access Controller

This block sits between a clocked request/acknowledge port and an external asynchronous static RAM that holds 256K one-bit words. The RAM has an 18-bit address, separate input and output data pins, an active-low select and an active-low write strobe. Each request is a single read or a single write. The controller registers the address and write bit when it accepts a request. It then holds the select low, with the write strobe low for a write or high for a read, for a whole number of clock cycles. That count is derived from nanosecond timing parameters and the clock period, always rounded up.

The write window is the overlap of select low and write strobe low. The controller opens both strobes on the same edge and closes both on the same edge. Address and data are presented when the window opens and stay unchanged until the next request is accepted, so setup and hold are met at both ends. A read keeps the write strobe high for the whole window and captures the output pin on the edge that closes it. Between accesses the select is held high for a turnaround time, which keeps the RAM deselected and in power-down whenever it is idle.

Top module: `bitsram_ctrl`

## Requirements
- R1: While reset is asserted, and whenever no access is in progress, `sramCeN` and `sramWeN` are 1, `ready` is 1, and `ack` and `rvalid` are 0.
- R2: A request is accepted only on a rising clock edge where `req` and `ready` are both 1. `ready` is 0 from the next cycle until the access and its turnaround finish. A request raised while `ready` is 0 and withdrawn before `ready` returns has no effect on the RAM pins or on `ack`.
- R3: For a write, `sramCeN` and `sramWeN` both go to 0 on the accepting edge and stay at 0 for WR_CYC cycles. WR_CYC is the largest of ceil(T_WP_NS/CLK_PERIOD_NS), ceil(T_SD_NS/CLK_PERIOD_NS), ceil(T_AW_NS/CLK_PERIOD_NS) and 1. `sramAddr` and `sramDin` take the request values on that same edge.
- R4: A write ends with `sramCeN` and `sramWeN` rising on the same edge. `sramAddr` and `sramDin` do not change while `sramCeN` is 0.
- R5: For a read, `sramCeN` goes to 0 on the accepting edge and stays at 0 for RD_CYC = max(1, ceil(T_AA_NS/CLK_PERIOD_NS)) cycles, while `sramWeN` stays at 1.
- R6: Read data is captured from `sramDout` on the edge that closes the read window, while `sramCeN` is still 0 and `sramWeN` is 1. It is never sampled while the pin may be high-impedance.
- R7: `ack` is a one-cycle pulse. It is first seen 1+WR_CYC cycles after the accepting edge for a write and 1+RD_CYC cycles after it for a read. `rvalid` pulses with `ack` for reads only.
- R8: `rdata` keeps the last captured value until the next read completes.
- R9: After each access, `sramCeN` stays at 1 for TURN_CYC cycles before `ready` returns to 1. TURN_CYC is the largest of 1, ceil(T_TURN_NS/CLK_PERIOD_NS) and ceil(T_WC_NS/CLK_PERIOD_NS) minus the shorter of WR_CYC and RD_CYC.
- R10: A bit written to an address is returned by a later read of that address, and a write to one address leaves every other address unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Request strobe |
| reqWe | input | 1 | 1 = write, 0 = read |
| reqAddr | input | ADDR_W | Request address |
| reqWdata | input | DATA_W | Write bit |
| ready | output | 1 | Controller can accept a request |
| ack | output | 1 | One-cycle completion pulse |
| rdata | output | DATA_W | Last captured read data |
| rvalid | output | 1 | Read data captured this cycle |
| sramAddr | output | ADDR_W | RAM address lines |
| sramCeN | output | 1 | RAM select, active low |
| sramWeN | output | 1 | RAM write strobe, active low |
| sramDin | output | DATA_W | RAM data-in pin |
| sramDout | input | DATA_W | RAM data-out pin |

## Verification
The bench runs the controller at a 10 ns clock with T_WP_NS=15 and T_AA_NS=25, which gives WR_CYC=2, RD_CYC=3 and TURN_CYC=1. With these values the write and read windows each span several cycles, so the cycle counter has to step down rather than finish on the accepting edge, and read latency differs from write latency. The bench's RAM model drives an unknown value on its output until 12 ns after any change of select, strobe or address. It stores an unknown bit if a write window is shorter than the RAM's timing requires. As a result, early sampling and short pulses show up at the ports as wrong data.

// File: rtl/bitsram_pkg.sv
package bitsram_pkg;

  typedef struct packed {
    logic load;     // register request address and data
    logic openWr;   // start a write window
    logic openRd;   // start a read window
    logic close;    // end the current window, pulse ack
    logic capture;  // sample the data-out pin
  } strobe_t;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_WRITE,
    ST_READ,
    ST_TURN
  } state_t;

  function automatic int ceilDiv(input int ns, input int per);
    return (ns + per - 1) / per;
  endfunction

  function automatic int maxOf(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  function automatic int minOf(input int a, input int b);
    return (a < b) ? a : b;
  endfunction

endpackage

// File: rtl/bitsram_ctrl_fsm.sv
module bitsram_ctrl_fsm
  import bitsram_pkg::*;
#(
  parameter int WR_CYC   = 1,
  parameter int RD_CYC   = 2,
  parameter int TURN_CYC = 1
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    req,
  input  logic    reqWe,
  output logic    ready,
  output strobe_t cmd
);

  localparam int MAX_CYC = maxOf(maxOf(WR_CYC, RD_CYC), TURN_CYC);
  localparam int CNT_W   = $clog2(MAX_CYC + 1);
  localparam logic [CNT_W-1:0] WR_LOAD   = CNT_W'(WR_CYC - 1);
  localparam logic [CNT_W-1:0] RD_LOAD   = CNT_W'(RD_CYC - 1);
  localparam logic [CNT_W-1:0] TURN_LOAD = CNT_W'(TURN_CYC - 1);

  state_t          state, stateNext;
  logic [CNT_W-1:0] cnt, cntNext;
  logic            cntDone;

  assign cntDone = (cnt == '0);
  assign ready   = (state == ST_IDLE);

  always_comb begin
    stateNext = state;
    cntNext   = cnt;
    cmd       = '0;
    unique case (state)
      ST_IDLE: begin
        if (req) begin
          cmd.load = 1'b1;
          if (reqWe) begin
            cmd.openWr = 1'b1;
            cntNext    = WR_LOAD;
            stateNext  = ST_WRITE;
          end else begin
            cmd.openRd = 1'b1;
            cntNext    = RD_LOAD;
            stateNext  = ST_READ;
          end
        end
      end
      ST_WRITE: begin
        if (cntDone) begin
          cmd.close = 1'b1;
          cntNext   = TURN_LOAD;
          stateNext = ST_TURN;
        end else begin
          cntNext = cnt - 1'b1;
        end
      end
      ST_READ: begin
        if (cntDone) begin
          cmd.close   = 1'b1;
          cmd.capture = 1'b1;
          cntNext     = TURN_LOAD;
          stateNext   = ST_TURN;
        end else begin
          cntNext = cnt - 1'b1;
        end
      end
      ST_TURN: begin
        if (cntDone) begin
          stateNext = ST_IDLE;
        end else begin
          cntNext = cnt - 1'b1;
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      cnt   <= '0;
    end else begin
      state <= stateNext;
      cnt   <= cntNext;
    end
  end

  // R2
  busy_no_open_chk: assert property (@(posedge clk) disable iff (!rstN)
    !ready |-> !(cmd.openWr || cmd.openRd));

  // R7
  one_close_chk: assert property (@(posedge clk) disable iff (!rstN)
    cmd.close |=> !cmd.close);

endmodule

// File: rtl/bitsram_datapath.sv
module bitsram_datapath
  import bitsram_pkg::*;
#(
  parameter int ADDR_W = 18,
  parameter int DATA_W = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           cmd,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic [DATA_W-1:0] sramDout,
  output logic [ADDR_W-1:0] sramAddr,
  output logic              sramCeN,
  output logic              sramWeN,
  output logic [DATA_W-1:0] sramDin,
  output logic              ack,
  output logic              rvalid,
  output logic [DATA_W-1:0] rdata
);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sramAddr <= '0;
      sramDin  <= '0;
    end else if (cmd.load) begin
      sramAddr <= reqAddr;
      sramDin  <= reqWdata;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sramCeN <= 1'b1;
      sramWeN <= 1'b1;
    end else if (cmd.close) begin
      sramCeN <= 1'b1;
      sramWeN <= 1'b1;
    end else if (cmd.openWr) begin
      sramCeN <= 1'b0;
      sramWeN <= 1'b0;
    end else if (cmd.openRd) begin
      sramCeN <= 1'b0;
      sramWeN <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ack    <= 1'b0;
      rvalid <= 1'b0;
      rdata  <= '0;
    end else begin
      ack    <= cmd.close;
      rvalid <= cmd.capture;
      if (cmd.capture) rdata <= sramDout;
    end
  end

  // R6
  capture_window_chk: assert property (@(posedge clk) disable iff (!rstN)
    cmd.capture |-> (!sramCeN && sramWeN));

  // R4
  addr_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!sramCeN && !$past(sramCeN)) |-> ($stable(sramAddr) && $stable(sramDin)));

  // R4
  write_end_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sramWeN) |-> sramCeN);

  // R9
  turnaround_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sramCeN) |=> sramCeN);

  // R7
  ack_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    ack |=> !ack);

  // R5
  read_we_high_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!sramCeN && $past(!sramCeN) && $past(sramWeN)) |-> sramWeN);

endmodule

// File: rtl/bitsram_ctrl.sv
module bitsram_ctrl
  import bitsram_pkg::*;
#(
  parameter int ADDR_W        = 18,
  parameter int DATA_W        = 1,
  parameter int CLK_PERIOD_NS = 10,
  parameter int T_WP_NS       = 8,
  parameter int T_SD_NS       = 8,
  parameter int T_AW_NS       = 9,
  parameter int T_AA_NS       = 12,
  parameter int T_WC_NS       = 12,
  parameter int T_TURN_NS     = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              req,
  input  logic              reqWe,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  output logic              ready,
  output logic              ack,
  output logic [DATA_W-1:0] rdata,
  output logic              rvalid,
  output logic [ADDR_W-1:0] sramAddr,
  output logic              sramCeN,
  output logic              sramWeN,
  output logic [DATA_W-1:0] sramDin,
  input  logic [DATA_W-1:0] sramDout
);

  localparam int WR_CYC = maxOf(1, maxOf(ceilDiv(T_WP_NS, CLK_PERIOD_NS),
                          maxOf(ceilDiv(T_SD_NS, CLK_PERIOD_NS),
                                ceilDiv(T_AW_NS, CLK_PERIOD_NS))));
  localparam int RD_CYC = maxOf(1, ceilDiv(T_AA_NS, CLK_PERIOD_NS));
  localparam int TURN_CYC = maxOf(1, maxOf(ceilDiv(T_TURN_NS, CLK_PERIOD_NS),
                            ceilDiv(T_WC_NS, CLK_PERIOD_NS) - minOf(WR_CYC, RD_CYC)));

  strobe_t cmd;

  bitsram_ctrl_fsm #(
    .WR_CYC  (WR_CYC),
    .RD_CYC  (RD_CYC),
    .TURN_CYC(TURN_CYC)
  ) u_fsm (
    .clk  (clk),
    .rstN (rstN),
    .req  (req),
    .reqWe(reqWe),
    .ready(ready),
    .cmd  (cmd)
  );

  bitsram_datapath #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .cmd     (cmd),
    .reqAddr (reqAddr),
    .reqWdata(reqWdata),
    .sramDout(sramDout),
    .sramAddr(sramAddr),
    .sramCeN (sramCeN),
    .sramWeN (sramWeN),
    .sramDin (sramDin),
    .ack     (ack),
    .rvalid  (rvalid),
    .rdata   (rdata)
  );

  // R1
  idle_deselect_chk: assert property (@(posedge clk) disable iff (!rstN)
    ready |-> (sramCeN && sramWeN && !ack));

  // R7
  rvalid_with_ack_chk: assert property (@(posedge clk) disable iff (!rstN)
    rvalid |-> ack);

endmodule

// File: tb/sim_bitsram_ctrl.sv
`timescale 1ns/1ps
module sim_bitsram_ctrl;

  localparam int EXP_WR   = 2;  // ceil(15/10)
  localparam int EXP_RD   = 3;  // ceil(25/10)
  localparam int EXP_TURN = 1;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        req = 1'b0;
  logic        reqWe = 1'b0;
  logic [17:0] reqAddr = '0;
  logic        reqWdata = 1'b0;
  logic        ready, ack, rvalid;
  logic        rdata;
  logic [17:0] sramAddr;
  logic        sramCeN, sramWeN, sramDin;
  logic        modelDout = 1'bx;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  bitsram_ctrl #(
    .CLK_PERIOD_NS(10),
    .T_WP_NS(15),
    .T_AA_NS(25)
  ) u0 (
    .clk(clk), .rstN(rstN), .req(req), .reqWe(reqWe), .reqAddr(reqAddr),
    .reqWdata(reqWdata), .ready(ready), .ack(ack), .rdata(rdata),
    .rvalid(rvalid), .sramAddr(sramAddr), .sramCeN(sramCeN),
    .sramWeN(sramWeN), .sramDin(sramDin), .sramDout(modelDout)
  );

  // ---------------- RAM model ----------------
  logic memArr [int unsigned];
  int unsigned gen = 0;
  time wStart = 0, addrT = 0, dinT = 0;
  bit  inWrite = 1'b0;

  always @(sramAddr) addrT = $time;
  always @(sramDin)  dinT  = $time;

  always @(sramCeN or sramWeN) begin
    if (!sramCeN && !sramWeN) begin
      if (!inWrite) begin
        inWrite = 1'b1;
        wStart  = $time;
      end
    end else if (inWrite) begin
      inWrite = 1'b0;
      if (($time - wStart >= 8) && ($time - dinT >= 8) && ($time - addrT >= 9))
        memArr[sramAddr] = sramDin;
      else
        memArr[sramAddr] = 1'bx;
    end
  end

  always @(sramCeN or sramWeN or sramAddr) begin
    gen = gen + 1;
    modelDout = 1'bx;
    fork
      begin
        automatic int unsigned tag = gen;
        #12;
        if (tag == gen && !sramCeN && sramWeN)
          modelDout = memArr.exists(sramAddr) ? memArr[sramAddr] : 1'bx;
      end
    join_none
  end

  // ---------------- checking helpers ----------------
  task automatic check(input bit ok, input string rq, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", rq, act, exp, $time);
    end
  endtask

  task automatic access(input bit w, input logic [17:0] a, input logic d,
                        input logic expBit);
    int lat;
    @(negedge clk);
    req = 1'b1; reqWe = w; reqAddr = a; reqWdata = d;
    @(posedge clk);
    @(negedge clk);
    req = 1'b0;
    // R3 R5: strobes right after the accepting edge
    check(sramCeN == 1'b0, "R3/R5 ceN low", {31'd0, sramCeN}, 32'd0);
    check(sramWeN == !w, "R3/R5 weN level", {31'd0, sramWeN}, {31'd0, !w});
    check(ready == 1'b0, "R2 ready drops", {31'd0, ready}, 32'd0);
    lat = 1;
    while (!ack && lat < 20) begin
      @(posedge clk); @(negedge clk);
      lat++;
    end
    // R7 latency
    check(lat == (w ? 1 + EXP_WR : 1 + EXP_RD), "R7 ack latency", lat,
          w ? 1 + EXP_WR : 1 + EXP_RD);
    check(sramCeN && sramWeN, "R4 strobes high at end", {30'd0, sramCeN, sramWeN}, 32'd3);
    check(rvalid == !w, "R7 rvalid only for reads", {31'd0, rvalid}, {31'd0, !w});
    if (!w) check(rdata === expBit, "R10 read data", {31'd0, rdata}, {31'd0, expBit});
    for (int t = 0; t < EXP_TURN; t++) begin
      @(posedge clk); @(negedge clk);
    end
    check(ack == 1'b0, "R7 ack one cycle", {31'd0, ack}, 32'd0);
    check(ready == 1'b1 && sramCeN, "R9 ready after turnaround",
          {30'd0, ready, sramCeN}, 32'd3);
  endtask

  // {write, addr[17:0], wdata, expected}
  localparam logic [20:0] VEC [13] = '{
    {1'b1, 18'h00000, 1'b1, 1'b0},
    {1'b1, 18'h3FFFF, 1'b0, 1'b0},
    {1'b1, 18'h15555, 1'b1, 1'b0},
    {1'b1, 18'h2AAAA, 1'b1, 1'b0},
    {1'b0, 18'h00000, 1'b0, 1'b1},
    {1'b0, 18'h3FFFF, 1'b0, 1'b0},
    {1'b0, 18'h15555, 1'b0, 1'b1},
    {1'b1, 18'h00000, 1'b0, 1'b0},
    {1'b0, 18'h00000, 1'b0, 1'b0},
    {1'b0, 18'h2AAAA, 1'b0, 1'b1},
    {1'b1, 18'h00001, 1'b1, 1'b0},
    {1'b0, 18'h00001, 1'b0, 1'b1},
    {1'b0, 18'h00000, 1'b0, 1'b0}
  };

  initial begin
    #2_000_000;
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    bit heldBit;
    // R1: reset state
    repeat (3) @(negedge clk);
    check(ready && sramCeN && sramWeN && !ack && !rvalid, "R1 reset state",
          {27'd0, ready, sramCeN, sramWeN, ack, rvalid}, 32'h1C);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    check(ready && sramCeN && sramWeN, "R1 idle deselect",
          {29'd0, ready, sramCeN, sramWeN}, 32'h7);

    // Vector table: R3 R4 R5 R6 R7 R10
    for (int i = 0; i < 13; i++)
      access(VEC[i][20], VEC[i][19:2], VEC[i][1], VEC[i][0]);

    // R2: request while busy is ignored
    access(1'b1, 18'h12345, 1'b0, 1'b0);
    @(negedge clk);
    req = 1'b1; reqWe = 1'b0; reqAddr = 18'h00001;
    @(posedge clk); @(negedge clk);
    req = 1'b0;
    @(negedge clk);
    reqWe = 1'b1; reqAddr = 18'h12345; reqWdata = 1'b1; req = 1'b1;
    @(posedge clk); @(negedge clk);
    req = 1'b0;
    while (!ready) begin
      @(posedge clk); @(negedge clk);
    end
    repeat (3) begin
      @(posedge clk); @(negedge clk);
      check(!ack && sramCeN && sramWeN, "R2 busy request ignored",
            {29'd0, ack, sramCeN, sramWeN}, 32'h3);
    end
    access(1'b0, 18'h12345, 1'b0, 1'b0);

    // R8: rdata held across a write
    access(1'b0, 18'h2AAAA, 1'b0, 1'b1);
    heldBit = rdata;
    @(negedge clk);
    req = 1'b1; reqWe = 1'b1; reqAddr = 18'h00007; reqWdata = 1'b0;
    @(posedge clk); @(negedge clk);
    req = 1'b0;
    while (!ready) begin
      check(rdata == heldBit && !rvalid, "R8 rdata held",
            {30'd0, rvalid, rdata}, {31'd0, heldBit});
      @(posedge clk); @(negedge clk);
    end

    // R1: reset during a write deselects at once
    @(negedge clk);
    req = 1'b1; reqWe = 1'b1; reqAddr = 18'h00002; reqWdata = 1'b1;
    @(posedge clk); @(negedge clk);
    req = 1'b0;
    rstN = 1'b0;
    #1;
    check(sramCeN && sramWeN && ready, "R1 reset mid-access",
          {29'd0, sramCeN, sramWeN, ready}, 32'h7);
    @(negedge clk);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    check(ready && !ack && sramCeN, "R1 idle after reset",
          {29'd0, ready, ack, sramCeN}, 32'h5);
    access(1'b0, 18'h15555, 1'b0, 1'b1);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule